// File: doc/BRIEF.md
# Framed Serial Result Port

This block is the slave side of a converter's serial port. An external host supplies a serial clock, a receive-frame strobe, a transmit-frame strobe and a data line into the port. The port drives one data line back. During one framed transfer it sends the most recently latched 10-bit conversion result, most significant bit first. In the same transfer it collects a 10-bit control word from the host. A bit counter caps every transfer at a fixed number of serial clocks. Once the cap is reached, further serial clocks do nothing, so the host may leave the clock running.

The port runs on a fast system clock. All four serial-side inputs pass through two-flop synchronisers and are edge-detected in that clock domain. The conversion sequencer hands results in through a valid/ready load channel. A result offered while a transfer is in flight goes into a one-deep holding slot. While that slot is full, ready is low, and a result the sequencer withdraws before ready returns is lost. A completed control word leaves on a one-cycle valid strobe. That output has no back-pressure, so the consumer must take it on that cycle.

Top module: `serport_framed`

## Requirements
- R1: While reset is held and after it is released, `sdo` is 0, `ctl_valid` is 0 and `res_ready` is 1.
- R2: A rising edge on `rx_frame` or a falling edge on `tx_frame` re-arms the port: the bit count goes back to zero and the next transfer starts again from bit 9.
- R3: Serial clock edges seen before the port is armed are ignored. The first rising serial clock edge after arming starts the transfer.
- R4: On each of the 10 accepted rising serial clock edges, `sdo` presents the next bit of the latched result, bit 9 first. `sdo` updates on the third system clock edge that samples the new `sck` level, and holds between rising edges.
- R5: `sdi` is sampled on each of the 10 falling serial clock edges, and the first bit sampled becomes bit 9. After the tenth sample, `ctl_valid` is high for exactly one cycle with the assembled word on `ctl_data`.
- R6: Once 10 bits have been exchanged, further serial clock edges change neither `sdo` nor `ctl_valid` until the port is re-armed.
- R7: A result accepted while a transfer is in progress does not alter that transfer. It becomes the latched result after the transfer ends or is aborted.
- R8: A load completes only when `res_valid` and `res_ready` are both high. `res_ready` stays low from the cycle after a result is accepted into the holding slot until that result has been latched. A result offered only while `res_ready` is low is never used.
- R9: Re-arming in the middle of a transfer abandons it: no `ctl_valid` pulse is produced for the partial word, and the next transfer starts from bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | External serial clock, asynchronous to `clk` |
| rx_frame | input | 1 | Receive-frame strobe; its rising edge re-arms the port |
| tx_frame | input | 1 | Transmit-frame strobe; its falling edge re-arms the port |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| res_valid | input | 1 | Conversion result offered |
| res_ready | output | 1 | Port can take a result this cycle |
| res_data | input | 10 | Conversion result |
| ctl_valid | output | 1 | One-cycle strobe: received control word is complete |
| ctl_data | output | 10 | Received control word |

## Verification
A wrong bit count or transfer state shows up on `sdo` within three system clocks of the first misplaced rising serial edge. It also shows as a `ctl_valid` pulse that is missing, early, or carries a shifted word. A holding slot that is corrupted or never emptied shows on `res_ready` on the cycle after it goes wrong. If the slot is drained too early, the result appears on `sdo` one transfer early. The bench runs a behavioural model alongside the port and compares `sdo`, `res_ready`, `ctl_valid` and `ctl_data` on every system clock. Any of these faults is therefore flagged in the cycle it first becomes visible.

// File: rtl/serport_pkg.sv
package serport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_ACTIVE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/serport_sync.sv
module serport_sync #(
  parameter int          N      = 4,
  parameter int          STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  // One synchroniser chain per input, plus one extra flop used for edge detection
  for (genvar g = 0; g < N; g++) begin : g_chain
    logic [STAGES:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL[g]}};
      else        chain <= {chain[STAGES-1:0], async_in[g]};
    end
    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~chain[STAGES];
    assign fall[g]  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/serport_bitctl.sv
module serport_bitctl
  import serport_pkg::*;
#(
  parameter  int WORD_W = 10,
  localparam int EDGES  = 2 * WORD_W,
  localparam int CNT_W  = $clog2(EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             sck_rise,
  input  logic             sck_fall,
  output xfer_state_e      st,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_first,
  output logic             ev_tx,
  output logic             ev_rx,
  output logic             ev_last
);
  // cnt counts accepted serial edges: an even count expects a rise, an odd count a fall
  always_comb begin
    ev_first = !arm && (st == ST_ARMED)  && sck_rise;
    ev_tx    = !arm && (st == ST_ACTIVE) && sck_rise && !cnt[0];
    ev_rx    = !arm && (st == ST_ACTIVE) && sck_fall &&  cnt[0];
    ev_last  = ev_rx && (cnt == CNT_W'(EDGES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (arm) begin
      st  <= ST_ARMED;
      cnt <= '0;
    end else if (ev_first) begin
      st  <= ST_ACTIVE;
      cnt <= CNT_W'(1);
    end else if (ev_tx || ev_rx) begin
      cnt <= cnt + CNT_W'(1);
      if (ev_last) st <= ST_IDLE;
    end
  end
endmodule

// File: rtl/serport_datapath.sv
module serport_datapath #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              ev_first,
  input  logic              ev_tx,
  input  logic              ev_rx,
  input  logic              ev_last,
  input  logic              sdi_s,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data,
  output logic              sdo,
  output logic              ctl_valid,
  output logic [WORD_W-1:0] ctl_data
);
  logic [WORD_W-1:0] latest, pend, tx_sh, rx_sh;
  logic              pend_v;
  logic              accept;

  assign res_ready = !pend_v;
  assign accept    = res_valid && !pend_v;

  // Serial shifting: outgoing word on rising edges, incoming word on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo       <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      ctl_valid <= 1'b0;
      ctl_data  <= '0;
    end else begin
      ctl_valid <= 1'b0;
      if (ev_first) begin
        sdo   <= latest[WORD_W-1];
        tx_sh <= {latest[WORD_W-2:0], 1'b0};
      end else if (ev_tx) begin
        sdo   <= tx_sh[WORD_W-1];
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (ev_rx) rx_sh <= {rx_sh[WORD_W-2:0], sdi_s};
      if (ev_last) begin
        ctl_valid <= 1'b1;
        ctl_data  <= {rx_sh[WORD_W-2:0], sdi_s};
      end
    end
  end

  // Result latch with a one-deep holding slot used while a transfer is running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latest <= '0;
      pend   <= '0;
      pend_v <= 1'b0;
    end else if (busy) begin
      if (accept) begin
        pend   <= res_data;
        pend_v <= 1'b1;
      end
    end else if (pend_v) begin
      latest <= pend;
      pend_v <= 1'b0;
    end else if (accept) begin
      latest <= res_data;
    end
  end
endmodule

// File: rtl/serport_framed.sv
module serport_framed
  import serport_pkg::*;
#(
  parameter int WORD_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              rx_frame,
  input  logic              tx_frame,
  input  logic              sdi,
  output logic              sdo,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [WORD_W-1:0] res_data,
  output logic              ctl_valid,
  output logic [WORD_W-1:0] ctl_data
);
  localparam int CNT_W = $clog2(2 * WORD_W + 1);

  // Bit order of the synchronised inputs: 0 sck, 1 rx_frame, 2 tx_frame, 3 sdi
  logic [3:0] lvl, rise, fall;
  logic       sck_rise, sck_fall, arm, sdi_s;
  logic       ev_first, ev_tx, ev_rx, ev_last;
  xfer_state_e      st;
  logic [CNT_W-1:0] cnt;
  logic             unused_edges;

  serport_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({sdi, tx_frame, rx_frame, sck}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  assign sck_rise = rise[0];
  assign sck_fall = fall[0];
  assign arm      = rise[1] | fall[2];
  assign sdi_s    = lvl[3];
  assign unused_edges = ^{lvl[2:0], rise[3:2], fall[3], fall[1]};

  serport_bitctl #(.WORD_W(WORD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .arm(arm),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .st(st), .cnt(cnt),
    .ev_first(ev_first), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_last(ev_last)
  );

  serport_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .busy(st == ST_ACTIVE),
    .ev_first(ev_first), .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_last(ev_last),
    .sdi_s(sdi_s),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .sdo(sdo), .ctl_valid(ctl_valid), .ctl_data(ctl_data)
  );
endmodule

// File: rtl/serport_framed_chk.sv
module serport_framed_chk
  import serport_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              ctl_valid,
  input logic              res_valid,
  input logic              res_ready,
  input logic              sck_rise,
  input logic              sck_fall,
  input logic              arm,
  input xfer_state_e       st,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] latest
);
  // R4: the output bit only moves after an accepted serial rising edge
  a_r4_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo) |-> $past(sck_rise));

  // R5: the word strobe lasts one cycle and follows a serial falling edge
  a_r5_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |=> !ctl_valid);
  a_r5_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_valid |-> $past(sck_fall));

  // R6: a finished or never-armed port stays quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_IDLE) && !$past(arm) |-> $stable(sdo) && !ctl_valid);

  // R7: the latched result is frozen while a transfer runs
  a_r7_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE) |=> $stable(latest));

  // R8: ready only drops after a load taken during a transfer
  a_r8_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_ready) |-> $past(res_valid) && ($past(st) == ST_ACTIVE));

  // R9 / R2: re-arming clears the count and suppresses any strobe
  a_r9_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st == ST_ARMED) && (cnt == '0) && !ctl_valid);
endmodule

bind serport_framed serport_framed_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .ctl_valid(ctl_valid),
  .res_valid(res_valid), .res_ready(res_ready),
  .sck_rise(sck_rise), .sck_fall(sck_fall), .arm(arm),
  .st(st), .cnt(cnt), .latest(u_dp.latest)
);

// File: tb/test_serport_framed.sv
`timescale 1ns/100ps
module test_serport_framed;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, rx_frame = 1'b0, tx_frame = 1'b1, sdi = 1'b0;
  logic res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic sdo, res_ready, ctl_valid;
  logic [W-1:0] ctl_data;

  int vectors = 0, miscompares = 0, pulses = 0;
  logic [W-1:0] last_ctl = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serport_framed i_serport_framed (
    .clk(clk), .rst_n(rst_n), .sck(sck), .rx_frame(rx_frame), .tx_frame(tx_frame),
    .sdi(sdi), .sdo(sdo), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .ctl_valid(ctl_valid), .ctl_data(ctl_data)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0] h1, h2, h3;
  int mode, e, old_mode;
  logic m_sdo, m_valid, m_pv, arm_m, rise_m, fall_m, acc_m;
  logic [W-1:0] m_data, m_latest, m_pend, m_rx, m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 4'b0100; h2 = 4'b0100; h3 = 4'b0100;
      mode = 0; e = 0; m_sdo = 0; m_valid = 0; m_pv = 0;
      m_data = '0; m_latest = '0; m_pend = '0; m_rx = '0; m_word = '0;
    end else begin
      arm_m  = (h2[1] & !h3[1]) | (!h2[2] & h3[2]);
      rise_m = h2[0] & !h3[0];
      fall_m = !h2[0] & h3[0];
      acc_m  = res_valid && !m_pv;
      old_mode = mode;
      m_valid = 0;
      if (arm_m) begin
        mode = 1; e = 0;
      end else if (mode == 1 && rise_m) begin
        m_word = m_latest; m_sdo = m_word[W-1]; e = 1; mode = 2;
      end else if (mode == 2) begin
        if (rise_m && (e % 2 == 0)) begin
          m_sdo = m_word[W-1-e/2]; e++;
        end else if (fall_m && (e % 2 == 1)) begin
          m_rx = {m_rx[W-2:0], h2[3]}; e++;
          if (e == 2*W) begin m_valid = 1; m_data = m_rx; mode = 0; end
        end
      end
      if (old_mode == 2) begin
        if (acc_m) begin m_pend = res_data; m_pv = 1; end
      end else if (m_pv) begin
        m_latest = m_pend; m_pv = 0;
      end else if (acc_m) begin
        m_latest = res_data;
      end
      h3 = h2; h2 = h1; h1 = {sdi, tx_frame, rx_frame, sck};
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (sdo !== m_sdo) begin
      miscompares++; $display("FAIL R4 sdo act=%0b exp=%0b t=%0t", sdo, m_sdo, $time);
    end
    if (ctl_valid !== m_valid) begin
      miscompares++; $display("FAIL R5 ctl_valid act=%0b exp=%0b t=%0t", ctl_valid, m_valid, $time);
    end
    if (ctl_data !== m_data) begin
      miscompares++; $display("FAIL R5 ctl_data act=%h exp=%h t=%0t", ctl_data, m_data, $time);
    end
    if (res_ready !== !m_pv) begin
      miscompares++; $display("FAIL R8 res_ready act=%0b exp=%0b t=%0t", res_ready, !m_pv, $time);
    end
    if (ctl_valid === 1'b1) begin pulses++; last_ctl = ctl_data; end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic sck_cycle(input logic b, output logic o);
    sdi = b; sck = 1'b1; tick(4);
    o = sdo;
    sck = 1'b0; tick(4);
  endtask

  task automatic xfer(input logic [W-1:0] w, output logic [W-1:0] got);
    logic o;
    for (int i = W-1; i >= 0; i--) begin sck_cycle(w[i], o); got[i] = o; end
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk); res_valid = 1'b1; res_data = v;
    while (!res_ready) @(negedge clk);
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic arm_rx();
    rx_frame = 1'b1; tick(4); rx_frame = 1'b0; tick(4);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    logic [W-1:0] got;
    logic o;
    int p0;
    tick(6); rst_n = 1'b1; tick(3);
    check("R1 sdo", sdo, 0);
    check("R1 ctl_valid", ctl_valid, 0);
    check("R1 res_ready", res_ready, 1);

    // R3: serial clocks before any arming do nothing
    for (int i = 0; i < 3; i++) sck_cycle(1'b1, o);
    check("R3 sdo unarmed", sdo, 0);
    check("R3 no strobe unarmed", pulses, 0);

    // R4/R5: basic transfer armed by rx_frame rising
    load(10'h2B5);
    arm_rx();
    xfer(10'h1C3, got);
    tick(4);
    check("R4 result bits", got, 10'h2B5);
    check("R5 strobe count", pulses, 1);
    check("R5 control word", last_ctl, 10'h1C3);

    // R6: extra clocks after the tenth bit are ignored
    for (int i = 0; i < 4; i++) sck_cycle(1'b0, o);
    check("R6 sdo held", sdo, 1);
    check("R6 no extra strobe", pulses, 1);

    // R2: arming by tx_frame falling
    tx_frame = 1'b0; tick(8);
    xfer(10'h0F0, got);
    tick(4); tx_frame = 1'b1; tick(4);
    check("R2 result bits", got, 10'h2B5);
    check("R2 control word", last_ctl, 10'h0F0);

    // R7/R8: load during a transfer is held; a second offer is refused
    arm_rx();
    for (int i = W-1; i >= 5; i--) begin sck_cycle(1'b1, o); got[i] = o; end
    load(10'h155);
    tick(1);
    check("R8 ready low while held", res_ready, 0);
    res_valid = 1'b1; res_data = 10'h3FF; tick(6); res_valid = 1'b0;
    for (int i = 4; i >= 0; i--) begin sck_cycle(1'b0, o); got[i] = o; end
    tick(4);
    check("R7 transfer unchanged", got, 10'h2B5);
    check("R8 ready back", res_ready, 1);
    arm_rx();
    xfer(10'h2AA, got);
    tick(4);
    check("R7 held result next", got, 10'h155);
    check("R8 refused offer unused", got == 10'h3FF, 0);

    // R9: abort mid-transfer, then a full transfer
    p0 = pulses;
    arm_rx();
    for (int i = 0; i < 4; i++) sck_cycle(1'b1, o);
    arm_rx();
    check("R9 no strobe on abort", pulses, p0);
    xfer(10'h301, got);
    tick(4);
    check("R9 restart from top bit", got, 10'h155);
    check("R9 single strobe", pulses, p0 + 1);
    check("R9 control word", last_ctl, 10'h301);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule